// File: doc/BRIEF.md
# Time-Digit Hold/Busy Access Interlock

This block sits beside a time-of-day counter and protects host reads and writes of its digit registers, seconds through weekday, while those digits continue to advance once per second. The host sets a hold bit to freeze the digits. On the write that sets hold, the block samples whether a carry ripple is in progress and presents the result as a busy status. Digit access is granted only while hold is set and the sampled busy is clear. Accesses to control registers are always granted.

While hold is set, the first one-second tick is remembered and later ticks are discarded. The remembered tick is released as a single advance pulse as soon as hold drops. Every advance pulse, whether live or deferred, opens a "digits updating" window of a programmable number of system-clock cycles. This window models the bounded ripple time of the counter. Dropping chip select clears hold.

Top module: `tod_hold_interlock`

## Requirements
- R1: After reset, hold_o is 0, busy_o is 1, adv_pulse is 0, ripple_o is 0, and no digit access is granted.
- R2: A clock edge with cs=1 and wr_en=1 loads wr_hold into hold_o. A clock edge with cs=1 and wr_en=0 leaves hold_o unchanged.
- R3: A clock edge with cs=0 clears hold_o, whatever wr_en and wr_hold are.
- R4: Whenever hold_o is 0, busy_o reads 1.
- R5: A tick_1hz pulse sampled while hold_o is 0 makes adv_pulse 1 for exactly the following cycle.
- R6: A tick sampled while hold_o is 1 produces no adv_pulse while hold_o stays 1. It produces one adv_pulse in the cycle after the first cycle in which hold_o reads 0 again.
- R7: However many ticks arrive during one hold period, exactly one deferred adv_pulse results.
- R8: ripple_o is 1 from each adv_pulse cycle onward for BUSY_CYC cycles. A new adv_pulse restarts the full window.
- R9: A write with cs=1, wr_en=1 and wr_hold=1 captures into busy_o whether ripple_o is 1 or an advance is being launched in that cycle. busy_o keeps that value while hold stays 1, until the next such write.
- R10: With acc_req=1 and cs=1, a digit access (acc_digit=1) is granted only when hold_o=1 and busy_o=0. A control access (acc_digit=0) is granted regardless of hold and busy. Nothing is granted with cs=0.
- R11: If a live tick arrives in the very cycle the deferred tick is being released, both are delivered as two adv_pulse cycles back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| cs | input | 1 | Host chip select, active high; low clears hold |
| wr_en | input | 1 | Host write strobe for the hold bit |
| wr_hold | input | 1 | Hold value written by the host |
| acc_req | input | 1 | Host register access request |
| acc_digit | input | 1 | 1 = digit register, 0 = control register |
| hold_o | output | 1 | Current hold bit |
| busy_o | output | 1 | Busy status read by the host |
| acc_grant | output | 1 | Access permitted this cycle |
| adv_pulse | output | 1 | Advance the digit counters by one second |
| ripple_o | output | 1 | Digits updating window |

## Verification
On every cycle, the assertions check these invariants: chip-select release clears hold, busy reads 1 whenever hold is clear, no advance pulse occurs inside a continuous hold, busy stays frozen between hold writes, a digit grant implies hold set with busy clear, and each advance pulse opens the ripple window. Only the bench scenarios can show the counting behaviours. These are the exact length of the ripple window and its restart, that several ticks in one hold collapse into a single deferred pulse, the timing of that pulse after release, and the back-to-back delivery when a live tick collides with the release cycle.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    typedef struct packed {
        logic sel;
        logic wr;
        logic hold_bit;
    } host_req_t;

    typedef enum logic [1:0] {
        ADV_NONE  = 2'b00,
        ADV_LIVE  = 2'b01,
        ADV_DEFER = 2'b10,
        ADV_BOTH  = 2'b11
    } adv_src_e;

    function automatic logic hold_next(input host_req_t r, input logic cur);
        if (!r.sel)
            return 1'b0;
        if (r.wr)
            return r.hold_bit;
        return cur;
    endfunction

    function automatic logic hold_set_write(input host_req_t r);
        return r.sel & r.wr & r.hold_bit;
    endfunction

endpackage

// File: rtl/ilk_hold_ctl.sv
module ilk_hold_ctl
    import ilk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_req_t req,
    input  logic      ripple_now,
    output logic      hold_q,
    output logic      busy_lat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= 1'b0;
            busy_lat <= 1'b1;
        end else begin
            hold_q <= hold_next(req, hold_q);
            if (hold_set_write(req))
                busy_lat <= ripple_now;
        end
    end

endmodule

// File: rtl/ilk_tick_defer.sv
module ilk_tick_defer
    import ilk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hold_q,
    output logic adv_d,
    output logic adv_q
);

    logic     pend_q;
    logic     pend_d;
    adv_src_e src;

    assign src = adv_src_e'({~hold_q & pend_q, tick & ~hold_q});

    always_comb begin
        pend_d = pend_q;
        adv_d  = 1'b0;
        unique case (src)
            ADV_NONE:  pend_d = pend_q | (tick & hold_q);
            ADV_LIVE:  adv_d  = 1'b1;
            ADV_DEFER: begin
                adv_d  = 1'b1;
                pend_d = 1'b0;
            end
            ADV_BOTH:  begin
                adv_d  = 1'b1;
                pend_d = 1'b1;
            end
            default:   adv_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            adv_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            adv_q  <= adv_d;
        end
    end

endmodule

// File: rtl/ilk_ripple_timer.sv
module ilk_ripple_timer #(
    parameter int BUSY_CYC = 19000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);

    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(BUSY_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/tod_hold_interlock.sv
module tod_hold_interlock
    import ilk_pkg::*;
#(
    parameter int BUSY_CYC = 19000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_1hz,
    input  logic cs,
    input  logic wr_en,
    input  logic wr_hold,
    input  logic acc_req,
    input  logic acc_digit,
    output logic hold_o,
    output logic busy_o,
    output logic acc_grant,
    output logic adv_pulse,
    output logic ripple_o
);

    host_req_t req;
    logic      hold_q;
    logic      busy_lat;
    logic      adv_d;
    logic      adv_q;
    logic      rip_act;

    assign req = '{sel: cs, wr: wr_en, hold_bit: wr_hold};

    ilk_hold_ctl u_hold (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .ripple_now (rip_act | adv_d),
        .hold_q     (hold_q),
        .busy_lat   (busy_lat)
    );

    ilk_tick_defer u_defer (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_1hz),
        .hold_q (hold_q),
        .adv_d  (adv_d),
        .adv_q  (adv_q)
    );

    ilk_ripple_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (adv_d),
        .active (rip_act)
    );

    assign hold_o    = hold_q;
    assign busy_o    = hold_q ? busy_lat : 1'b1;
    assign adv_pulse = adv_q;
    assign ripple_o  = rip_act;
    assign acc_grant = acc_req & cs & (acc_digit ? (hold_q & ~busy_lat) : 1'b1);

endmodule

// File: rtl/ilk_chk.sv
module ilk_chk (
    input logic clk,
    input logic rst,
    input logic cs,
    input logic wr_en,
    input logic acc_digit,
    input logic hold_o,
    input logic busy_o,
    input logic acc_grant,
    input logic adv_pulse,
    input logic ripple_o
);

    p_cs_clears_r3: assert property (@(posedge clk) disable iff (rst)
        !cs |=> !hold_o);

    p_busy_released_r4: assert property (@(posedge clk) disable iff (rst)
        !hold_o |-> busy_o);

    p_no_adv_in_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (hold_o && $past(hold_o)) |-> !adv_pulse);

    p_ripple_opens_r8: assert property (@(posedge clk) disable iff (rst)
        adv_pulse |-> ripple_o);

    p_busy_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (hold_o && $past(hold_o) && !$past(cs && wr_en)) |-> $stable(busy_o));

    p_digit_grant_r10: assert property (@(posedge clk) disable iff (rst)
        (acc_grant && acc_digit) |-> (cs && hold_o && !busy_o));

endmodule

bind tod_hold_interlock ilk_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs        (cs),
    .wr_en     (wr_en),
    .acc_digit (acc_digit),
    .hold_o    (hold_o),
    .busy_o    (busy_o),
    .acc_grant (acc_grant),
    .adv_pulse (adv_pulse),
    .ripple_o  (ripple_o)
);

// File: tb/sim_tod_hold_interlock.sv
module sim_tod_hold_interlock;

    localparam int BC = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1hz = 1'b0;
    logic cs = 1'b0;
    logic wr_en = 1'b0;
    logic wr_hold = 1'b0;
    logic acc_req = 1'b0;
    logic acc_digit = 1'b0;
    logic hold_o, busy_o, acc_grant, adv_pulse, ripple_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tod_hold_interlock #(.BUSY_CYC(BC)) u0 (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .cs(cs), .wr_en(wr_en),
        .wr_hold(wr_hold), .acc_req(acc_req), .acc_digit(acc_digit),
        .hold_o(hold_o), .busy_o(busy_o), .acc_grant(acc_grant),
        .adv_pulse(adv_pulse), .ripple_o(ripple_o)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic write_hold(input logic v);
        wr_en = 1'b1; wr_hold = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < BC + 4; i++) step();
    endtask

    task automatic t_reset();
        cs = 1'b1; acc_req = 1'b1; acc_digit = 1'b1;
        #1;
        chk("R1 hold", hold_o, 0);
        chk("R1 busy", busy_o, 1);
        chk("R1 adv", adv_pulse, 0);
        chk("R1 ripple", ripple_o, 0);
        chk("R1 digit grant", acc_grant, 0);
        acc_req = 1'b0;
    endtask

    task automatic t_hold_write();
        write_hold(1'b1);
        chk("R2 hold set", hold_o, 1);
        step();
        chk("R2 no write keeps hold", hold_o, 1);
        write_hold(1'b0);
        chk("R2 hold clear", hold_o, 0);
        chk("R4 busy with hold 0", busy_o, 1);
    endtask

    task automatic t_cs_clear();
        write_hold(1'b1);
        cs = 1'b0; wr_en = 1'b1; wr_hold = 1'b1;
        step();
        chk("R3 cs low clears hold", hold_o, 0);
        wr_en = 1'b0; cs = 1'b1;
        step();
        chk("R3 hold stays clear", hold_o, 0);
    endtask

    task automatic t_live_tick();
        int rip;
        tick_1hz = 1'b1;
        step();
        tick_1hz = 1'b0;
        chk("R5 adv after tick", adv_pulse, 1);
        rip = 0;
        for (int i = 0; i < BC + 4; i++) begin
            if (ripple_o) rip++;
            step();
            if (i == 0) chk("R5 adv single cycle", adv_pulse, 0);
        end
        chk("R8 ripple length", rip, BC);
    endtask

    task automatic t_defer();
        int pulses;
        write_hold(1'b1);
        chk("R9 busy idle capture", busy_o, 0);
        pulses = 0;
        for (int k = 0; k < 3; k++) begin
            tick_1hz = 1'b1;
            step();
            tick_1hz = 1'b0;
            for (int i = 0; i < 5; i++) begin
                if (adv_pulse) pulses++;
                step();
            end
        end
        chk("R6 no adv during hold", pulses, 0);
        write_hold(1'b0);
        chk("R6 adv not yet", adv_pulse, 0);
        step();
        chk("R6 deferred adv", adv_pulse, 1);
        pulses = 1;
        for (int i = 0; i < BC + 4; i++) begin
            step();
            if (adv_pulse) pulses++;
        end
        chk("R7 single deferred pulse", pulses, 1);
    endtask

    task automatic t_busy_capture();
        tick_1hz = 1'b1;
        step();
        tick_1hz = 1'b0;
        step();
        write_hold(1'b1);
        chk("R9 busy captured during ripple", busy_o, 1);
        acc_req = 1'b1; acc_digit = 1'b1;
        #1;
        chk("R10 digit denied when busy", acc_grant, 0);
        acc_req = 1'b0;
        wait_idle();
        chk("R9 busy frozen", busy_o, 1);
        write_hold(1'b1);
        chk("R9 busy resampled", busy_o, 0);
        acc_req = 1'b1; acc_digit = 1'b1;
        #1;
        chk("R10 digit granted", acc_grant, 1);
        cs = 1'b0;
        #1;
        chk("R10 no grant cs low", acc_grant, 0);
        step();
        cs = 1'b1; acc_digit = 1'b0;
        #1;
        chk("R10 control grant hold 0", acc_grant, 1);
        acc_req = 1'b0;
    endtask

    task automatic t_collide();
        int rip;
        write_hold(1'b1);
        tick_1hz = 1'b1;
        step();
        tick_1hz = 1'b0;
        step();
        write_hold(1'b0);
        tick_1hz = 1'b1;
        step();
        tick_1hz = 1'b0;
        chk("R11 first pulse", adv_pulse, 1);
        rip = ripple_o ? 1 : 0;
        step();
        chk("R11 second pulse", adv_pulse, 1);
        for (int i = 0; i < BC + 4; i++) begin
            if (ripple_o) rip++;
            step();
        end
        chk("R8 ripple restarts", rip, BC + 1);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        step();
        step();
        rst = 1'b0;
        #1;
        t_reset();
        t_hold_write();
        t_cs_clear();
        t_live_tick();
        t_defer();
        wait_idle();
        t_busy_capture();
        wait_idle();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule